// File: doc/BRIEF.md
# Bus Address Break Comparator

This block sits next to a processor bus and watches every access. Each break channel holds a programmed break address and a small control register. The control register chooses which kinds of bus cycle count, which bus masters may trigger a match, and how many low address bits are ignored. When a valid bus cycle satisfies a channel's settings, that channel pulses its break request for one clock. It also sets a sticky match flag that software can inspect and later clear.

Software reaches the registers through a plain single-cycle register port. Writes are strobed and take effect at the next clock edge. Reads are strobed, and the data is returned one clock later. The flag clears only through a read-then-write handshake, so a flag that software has not yet seen is never lost. Exception entry, stalling and servicing the break all belong to the logic around this block.

Top module: `bus_break_unit`

## Requirements
- R1: Register port offsets: `reg_addr` 0 is the address register of channel A, 1 its control register, 2 the address register of channel B, 3 its control register. Control layout: bit 7 match flag, bit 6 reads 0, bit 5 master select, bits 4:2 mask code, bits 1:0 cycle condition. After reset every register reads 0 and both break requests are 0. An address register reads back the 24-bit value written to it.
- R2: Mask code to ignored low address bits: 0 ignores none, 1 ignores bit 0, 2 bits 1:0, 3 bits 2:0, 4 bits 3:0, 5 bits 7:0, 6 bits 11:0, 7 bits 15:0. All remaining bits must be equal for a match.
- R3: Condition codes against `bus_type` (0 fetch, 1 data read, 2 data write, 3 no access): condition 0 matches fetch only, 1 matches read only, 2 matches write only, 3 matches read or write. `bus_type` 3 never matches.
- R4: With master select 0, only cycles with `bus_dma`=0 can match. With master select 1, cycles from either master can match.
- R5: A matching cycle with `bus_valid`=1 gives a `brk_req` pulse one clock later that lasts exactly one clock. No pulse results while `bus_valid`=0.
- R6: A match sets the channel's flag. Once set, the flag stays set until it is cleared as R7 allows.
- R7: A control write with bit 7 = 0 clears the flag only if a read of that control register has returned the flag as 1 since the last control write. A write with bit 7 = 1 never changes the flag.
- R8: If a match occurs in the same cycle as a clearing write, the flag remains 1.
- R9: A register write takes effect at the next clock. A bus cycle in the same clock as the write is compared against the old register contents.
- R10: `brk_any` is 1 in exactly the cycles in which any `brk_req` bit is 1.
- R11: Read data appears on `reg_rdata` one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select (channel, address/control) |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Registered read data |
| bus_valid | input | 1 | Monitored bus cycle is valid |
| bus_addr | input | 24 | Monitored bus address |
| bus_type | input | 2 | Cycle type: fetch, read, write, none |
| bus_dma | input | 1 | 1 when the transfer controller owns the cycle |
| brk_req | output | 2 | Per-channel break request pulse |
| brk_any | output | 1 | Combined break request pulse |

## Verification
The bench builds the block with its defaults: two channels and a 24-bit address. At this width every mask code can be tested, including the widest one that ignores 16 low bits, because a flipped bit 16 is still compared. With two channels, the bench can make them overlap, so both requests and the combined output fire together, and it can also fire each channel alone. A scoreboard stamps each expected break pattern with its due cycle. These patterns include a register write or a flag-clearing write that coincides with a bus cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CTL_W    = 8;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    COND_FETCH = 2'd0,
    COND_READ  = 2'd1,
    COND_WRITE = 2'd2,
    COND_RDWR  = 2'd3
  } cond_e;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_NONE  = 2'd3
  } cyc_e;

  typedef struct packed {
    logic       flag;
    logic       rsvd;
    logic       any_master;
    logic [2:0] mask_code;
    cond_e      cond;
  } ctl_t;
endpackage

// File: rtl/brk_addr_mask.sv
module brk_addr_mask #(
  parameter int ADDR_W = 24
) (
  input  logic [2:0]        code,
  output logic [ADDR_W-1:0] care
);
  logic [4:0]        ign;
  logic [ADDR_W-1:0] ones;

  assign ones = '1;

  always_comb begin
    case (code)
      3'd0:    ign = 5'd0;
      3'd1:    ign = 5'd1;
      3'd2:    ign = 5'd2;
      3'd3:    ign = 5'd3;
      3'd4:    ign = 5'd4;
      3'd5:    ign = 5'd8;
      3'd6:    ign = 5'd12;
      default: ign = 5'd16;
    endcase
  end

  assign care = ones << ign;
endmodule

// File: rtl/brk_cond_match.sv
module brk_cond_match
  import brk_pkg::*;
(
  input  cond_e      cond,
  input  logic       any_master,
  input  logic [1:0] bus_type,
  input  logic       bus_dma,
  output logic       ok
);
  logic type_ok;

  always_comb begin
    case (cond)
      COND_FETCH: type_ok = (bus_type == CYC_FETCH);
      COND_READ:  type_ok = (bus_type == CYC_READ);
      COND_WRITE: type_ok = (bus_type == CYC_WRITE);
      default:    type_ok = (bus_type == CYC_READ) || (bus_type == CYC_WRITE);
    endcase
  end

  assign ok = type_ok && (any_master || !bus_dma);
endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_we,
  input  logic              ctl_we,
  input  logic              ctl_re,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_type,
  input  logic              bus_dma,
  output logic [ADDR_W-1:0] addr_q,
  output ctl_t              ctl_q,
  output logic              hit,
  output logic              req
);
  logic [ADDR_W-1:0] care;
  logic              cyc_ok;
  logic              rd_seen;
  logic              clr_req;

  brk_addr_mask #(.ADDR_W(ADDR_W)) u_mask (
    .code (ctl_q.mask_code),
    .care (care)
  );

  brk_cond_match u_cond (
    .cond       (ctl_q.cond),
    .any_master (ctl_q.any_master),
    .bus_type   (bus_type),
    .bus_dma    (bus_dma),
    .ok         (cyc_ok)
  );

  assign hit     = bus_valid && cyc_ok && (((bus_addr ^ addr_q) & care) == '0);
  assign clr_req = ctl_we && !wdata[FLAG_BIT] && rd_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      ctl_q   <= '0;
      rd_seen <= 1'b0;
      req     <= 1'b0;
    end else begin
      req <= hit;
      if (addr_we) addr_q <= wdata;
      if (ctl_we) begin
        ctl_q.rsvd       <= 1'b0;
        ctl_q.any_master <= wdata[5];
        ctl_q.mask_code  <= wdata[4:2];
        ctl_q.cond       <= cond_e'(wdata[1:0]);
      end
      if (hit)          ctl_q.flag <= 1'b1;
      else if (clr_req) ctl_q.flag <= 1'b0;
      if (ctl_we)                    rd_seen <= 1'b0;
      else if (ctl_re && ctl_q.flag) rd_seen <= 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ctl_q == '0 && addr_q == '0 && !req));

  assert_pulse_needs_valid_R5: assert property (@(posedge clk) disable iff (rst)
    req |-> $past(bus_valid));

  assert_pulse_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    req |-> ctl_q.flag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.flag && !(ctl_we && !wdata[FLAG_BIT] && rd_seen)) |=> ctl_q.flag);

  assert_clear_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_q.flag) |-> ($past(rd_seen) && $past(ctl_we)));

  assert_match_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && hit) |=> ctl_q.flag);
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import brk_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 24,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RA_W  = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_type,
  input  logic              bus_dma,
  output logic [NUM_CH-1:0] brk_req,
  output logic              brk_any
);
  logic [ADDR_W-1:0] addr_arr [NUM_CH];
  ctl_t              ctl_arr  [NUM_CH];
  logic [NUM_CH-1:0] hit_vec;
  logic [CH_W-1:0]   sel;

  assign sel = reg_addr[RA_W-1:1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_sel;
    assign hit_sel = (sel == CH_W'(i));

    brk_channel #(.ADDR_W(ADDR_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .addr_we   (reg_we && hit_sel && !reg_addr[0]),
      .ctl_we    (reg_we && hit_sel &&  reg_addr[0]),
      .ctl_re    (reg_re && hit_sel &&  reg_addr[0]),
      .wdata     (reg_wdata),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_type  (bus_type),
      .bus_dma   (bus_dma),
      .addr_q    (addr_arr[i]),
      .ctl_q     (ctl_arr[i]),
      .hit       (hit_vec[i]),
      .req       (brk_req[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      brk_any   <= 1'b0;
    end else begin
      brk_any <= |hit_vec;
      if (reg_re) begin
        if (reg_addr[0]) reg_rdata <= {{(ADDR_W-CTL_W){1'b0}}, ctl_arr[sel]};
        else             reg_rdata <= addr_arr[sel];
      end
    end
  end

  assert_any_is_or_R10: assert property (@(posedge clk) disable iff (rst)
    brk_any == (|brk_req));

  assert_read_latency_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_re) |-> $stable(reg_rdata));
endmodule

// File: tb/bus_break_unit_bench.sv
module bus_break_unit_bench;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_type = 2'd3;
  logic          bus_dma = 1'b0;
  logic [1:0]    brk_req;
  logic          brk_any;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_break_unit #(.NUM_CH(2), .ADDR_W(AW)) u_bus_break_unit (
    .clk, .rst, .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata,
    .bus_valid, .bus_addr, .bus_type, .bus_dma, .brk_req, .brk_any
  );

  typedef struct {
    int       due;
    logic [1:0] req;
    string    tag;
  } exp_t;
  exp_t sb[$];

  // monitor: compare break outputs in the cycle each item falls due
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0 && sb[0].due == cyc) begin
      e = sb.pop_front();
      checks++;
      if (brk_req !== e.req || brk_any !== (|e.req)) begin
        fails++;
        $display("FAIL %s: req=%b any=%b expected req=%b any=%b",
                 e.tag, brk_req, brk_any, e.req, |e.req);
      end
    end
  end

  function automatic logic [AW-1:0] ctl(logic f, logic ms, logic [2:0] mc, logic [1:0] cd);
    return {16'd0, f, 1'b0, ms, mc, cd};
  endfunction

  function automatic int ign_bits(int code);
    case (code)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 4;  5: return 8;  6: return 12; default: return 16;
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [AW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [AW-1:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  // driver: present one bus cycle and push the expected break pattern
  task automatic drive(logic [AW-1:0] a, logic [1:0] t, logic dma, logic v);
    bus_valid = v; bus_addr = a; bus_type = t; bus_dma = dma;
  endtask

  task automatic bus(logic [AW-1:0] a, logic [1:0] t, logic dma, logic v,
                     logic [1:0] exp, string tag);
    drive(a, t, dma, v);
    sb.push_back('{cyc + 1, exp, tag});
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  localparam logic [AW-1:0] BASE = 24'h123456;
  localparam logic [AW-1:0] NEWA = 24'h00ABCD;

  initial begin
    logic [AW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 reset ctl A", brk_req, '0);
    rd(2'd1, d); check("R1 reset ctl A", d, '0);
    rd(2'd0, d); check("R1 reset addr A", d, '0);
    rd(2'd3, d); check("R1 reset ctl B", d, '0);

    wr(2'd0, BASE);
    rd(2'd0, d); check("R1 addr A readback", d, BASE);
    wr(2'd1, ctl(1'b0, 1'b0, 3'd0, 2'd0));
    rd(2'd1, d); check("R11 ctl A readback", d, ctl(1'b0, 1'b0, 3'd0, 2'd0));

    // R5 / R6 basic match
    bus(BASE, 2'd0, 1'b0, 1'b1, 2'b01, "R5 fetch match pulse");
    bus(BASE, 2'd3, 1'b0, 1'b0, 2'b00, "R5 pulse lasts one clock");
    rd(2'd1, d); check("R6 flag set", d, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    bus(BASE ^ 24'h1, 2'd0, 1'b0, 1'b1, 2'b00, "R2 code0 bit0 compared");

    // R2 every mask code
    for (int c = 0; c < 8; c++) begin
      int n;
      n = ign_bits(c);
      wr(2'd1, ctl(1'b1, 1'b0, 3'(c), 2'd0));
      if (n > 0)
        bus(BASE ^ (24'h1 << (n - 1)), 2'd0, 1'b0, 1'b1, 2'b01, "R2 ignored bit");
      bus(BASE ^ (24'h1 << n), 2'd0, 1'b0, 1'b1, 2'b00, "R2 compared bit");
    end

    // R3 condition codes
    for (int cd = 0; cd < 4; cd++) begin
      wr(2'd1, ctl(1'b1, 1'b0, 3'd0, 2'(cd)));
      for (int t = 0; t < 4; t++) begin
        logic e;
        e = (t != 3) && ((cd == t) || (cd == 3 && t != 0));
        bus(BASE, 2'(t), 1'b0, 1'b1, {1'b0, e}, "R3 cycle type");
      end
    end

    // R4 master select
    wr(2'd1, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    bus(BASE, 2'd0, 1'b1, 1'b1, 2'b00, "R4 dma blocked");
    bus(BASE, 2'd0, 1'b0, 1'b1, 2'b01, "R4 cpu allowed");
    wr(2'd1, ctl(1'b1, 1'b1, 3'd0, 2'd0));
    bus(BASE, 2'd0, 1'b1, 1'b1, 2'b01, "R4 dma allowed");
    bus(BASE, 2'd0, 1'b0, 1'b0, 2'b00, "R5 valid low");

    // R7 clear handshake
    wr(2'd1, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    wr(2'd1, ctl(1'b0, 1'b0, 3'd0, 2'd0));
    rd(2'd1, d); check("R7 write0 without read", d, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    wr(2'd1, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    rd(2'd1, d); check("R7 write1 no effect", d, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    wr(2'd1, ctl(1'b0, 1'b0, 3'd0, 2'd0));
    rd(2'd1, d); check("R7 cleared", d, ctl(1'b0, 1'b0, 3'd0, 2'd0));

    // R8 match coinciding with clearing write
    bus(BASE, 2'd0, 1'b0, 1'b1, 2'b01, "R8 set again");
    rd(2'd1, d); check("R8 flag before", d, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = ctl(1'b0, 1'b0, 3'd0, 2'd0);
    bus(BASE, 2'd0, 1'b0, 1'b1, 2'b01, "R8 coinciding match");
    reg_we = 1'b0;
    rd(2'd1, d); check("R8 flag kept", d, ctl(1'b1, 1'b0, 3'd0, 2'd0));

    // R9 old values used in the write cycle
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = NEWA;
    bus(BASE, 2'd0, 1'b0, 1'b1, 2'b01, "R9 old address");
    reg_we = 1'b0;
    bus(BASE, 2'd0, 1'b0, 1'b1, 2'b00, "R9 old address gone");
    bus(NEWA, 2'd0, 1'b0, 1'b1, 2'b01, "R9 new address");
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = ctl(1'b1, 1'b0, 3'd0, 2'd1);
    bus(NEWA, 2'd0, 1'b0, 1'b1, 2'b01, "R9 old condition");
    reg_we = 1'b0;
    bus(NEWA, 2'd0, 1'b0, 1'b1, 2'b00, "R9 new condition");

    // R10 both channels
    wr(2'd1, ctl(1'b1, 1'b0, 3'd0, 2'd0));
    wr(2'd2, NEWA);
    wr(2'd3, ctl(1'b0, 1'b0, 3'd0, 2'd0));
    rd(2'd2, d); check("R1 addr B readback", d, NEWA);
    bus(NEWA, 2'd0, 1'b0, 1'b1, 2'b11, "R10 both channels");
    wr(2'd3, ctl(1'b1, 1'b0, 3'd7, 2'd0));
    bus(24'h00FFFF, 2'd0, 1'b0, 1'b1, 2'b10, "R10 channel B only");
    wr(2'd1, ctl(1'b1, 1'b0, 3'd0, 2'd1));
    bus(NEWA, 2'd1, 1'b0, 1'b1, 2'b01, "R10 channel A only");
    bus(NEWA, 2'd3, 1'b0, 1'b0, 2'b00, "R10 idle");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5: %0d scoreboard items left, expected 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL R5: watchdog expired at cycle %0d, expected finish", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule